// File: doc/BRIEF.md
# Warp Issue Sequencer

This block is the issue front end of a throughput-oriented streaming multiprocessor. It keeps track of a pool of resident warps, each a group of 32 threads that share one instruction stream. When the lanes are free, it chooses one warp that is both ready and not blocked, then spreads that warp's instruction over the scalar lanes. Eight lanes serve 32 threads, so one warp instruction takes four cycles. The block can switch to a different warp at the next four-cycle boundary, so a warp that is waiting on memory does not hold up the others.

Each resident warp has a ready bit that comes from outside. A warp that has just been picked is blocked until its own acknowledge bit arrives. Every cycle the block shows the warp being issued, the beat index within that warp, and the thread number that each lane serves. The datapath, divergence handling and memory are outside this block.

Top module: `wis_issue_seq`

## Requirements
- R1: While reset is asserted, and after reset until a warp is picked, `issueValid` is 0 and `subCycle` is 0.
- R2: A picked warp appears on `warpId` for exactly four consecutive cycles with `issueValid` high. During those cycles `subCycle` runs 0, 1, 2, 3. A pick made at a clock edge is visible right after that edge.
- R3: While a warp is issuing, lane j (field `laneThread[5j+4:5j]`) carries thread number 8*`subCycle`+j.
- R4: A new warp is picked only when the block is idle or when `subCycle` is 3. A change to `warpReady` in the middle of a warp does not change `warpId` before the boundary.
- R5: At a boundary the block picks the first eligible warp found by searching upward from the last picked warp index plus one, wrapping from 23 to 0. After reset the search starts at warp 0. A warp is eligible when its `warpReady` bit is 1 and it is not blocked.
- R6: When no warp is eligible at a boundary, `issueValid` goes low in the next cycle and `subCycle` reads 0. While idle, a warp that becomes eligible is picked at the very next clock edge, whatever the cycle alignment.
- R7: Picking a warp blocks it. It stays blocked until a clock edge at which its `warpAck` bit is 1 and it is not being picked. If an acknowledge coincides with the pick of the same warp, the pick wins and the warp stays blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| warpReady | input | 24 | Per-warp ready bits, bit w for warp w |
| warpAck | input | 24 | Per-warp instruction-accepted bits; bit w unblocks warp w |
| issueValid | output | 1 | High while a warp instruction is being spread over the lanes |
| warpId | output | 5 | Index of the warp currently issuing |
| subCycle | output | 2 | Beat index within the current warp, 0 to 3 |
| laneThread | output | 40 | Eight 5-bit thread numbers, lane j at bits 5j+4:5j |

## Verification
The hardest case to reach from the ports is the interaction between blocking and acknowledge timing. This covers a warp issuing back to back because its acknowledge arrived during its own beats. It also covers the opposite case, where an acknowledge that lands exactly on the pick edge is lost, so the warp falls idle at the next boundary. The stimulus drives single-cycle acknowledge pulses aligned to the pick edge, and acknowledges held across whole beats, on the same warp. It also moves the ready bits in the middle of a warp and scatters ready warps across the index range so the round-robin search has to wrap.

// File: rtl/wis_pkg.sv
`timescale 1ns/1ps
package wis_pkg;
  localparam int WARP_COUNT   = 24;
  localparam int LANE_COUNT   = 8;
  localparam int WARP_THREADS = 32;

  // Strobes from control to the lane datapath
  typedef struct packed {
    logic startWarp;  // load a new warp at this boundary
    logic goIdle;     // nothing eligible at this boundary
  } seqStrobes_t;
endpackage

// File: rtl/wis_rr_pick.sv
`timescale 1ns/1ps
module wis_rr_pick #(
  parameter int NumWarps = 24,
  parameter int IdW      = 5
) (
  input  logic [NumWarps-1:0] eligible,
  input  logic [IdW-1:0]      lastIdx,
  output logic                found,
  output logic [IdW-1:0]      pick
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= NumWarps; i++) begin
      idx = int'(lastIdx) + i;
      if (idx >= NumWarps) idx = idx - NumWarps;
      if (!found && eligible[IdW'(idx)]) begin
        found = 1'b1;
        pick  = IdW'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_ctrl.sv
`timescale 1ns/1ps
module wis_ctrl
  import wis_pkg::*;
#(
  parameter int NumWarps = 24,
  parameter int IdW      = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumWarps-1:0] warpReady,
  input  logic [NumWarps-1:0] warpAck,
  input  logic                atBoundary,
  output seqStrobes_t         strobes,
  output logic [IdW-1:0]      selWarp
);
  logic [NumWarps-1:0] pending;
  logic [NumWarps-1:0] eligible;
  logic [NumWarps-1:0] pickMask;
  logic [IdW-1:0]      lastIdx;
  logic                found;
  logic [IdW-1:0]      pick;

  assign eligible = warpReady & ~pending;

  wis_rr_pick #(.NumWarps(NumWarps), .IdW(IdW)) u_pick (
    .eligible(eligible),
    .lastIdx (lastIdx),
    .found   (found),
    .pick    (pick)
  );

  always_comb begin
    strobes.startWarp = atBoundary & found;
    strobes.goIdle    = atBoundary & ~found;
    selWarp           = pick;
    pickMask          = strobes.startWarp ? (NumWarps'(1) << pick) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      lastIdx <= IdW'(NumWarps - 1);
    end else begin
      pending <= (pending & ~warpAck) | pickMask;
      if (strobes.startWarp) lastIdx <= pick;
    end
  end
endmodule

// File: rtl/wis_lanes.sv
`timescale 1ns/1ps
module wis_lanes
  import wis_pkg::*;
#(
  parameter int LaneCount = 8,
  parameter int IdW       = 5,
  parameter int SubW      = 2,
  parameter int SubCycles = 4,
  parameter int ThreadW   = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobes_t                  strobes,
  input  logic [IdW-1:0]               selWarp,
  output logic                         atBoundary,
  output logic                         issueValid,
  output logic [IdW-1:0]               warpId,
  output logic [SubW-1:0]              subCycle,
  output logic [LaneCount*ThreadW-1:0] laneThread
);
  localparam logic [SubW-1:0] LastSub = SubW'(SubCycles - 1);

  assign atBoundary = !issueValid || (subCycle == LastSub);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      warpId     <= '0;
      subCycle   <= '0;
    end else if (strobes.startWarp) begin
      issueValid <= 1'b1;
      warpId     <= selWarp;
      subCycle   <= '0;
    end else if (strobes.goIdle) begin
      issueValid <= 1'b0;
      subCycle   <= '0;
    end else if (issueValid) begin
      subCycle   <= subCycle + SubW'(1);
    end
  end

  for (genvar j = 0; j < LaneCount; j++) begin : g_lane
    assign laneThread[j*ThreadW +: ThreadW] =
      ThreadW'(int'(subCycle) * LaneCount + j);
  end
endmodule

// File: rtl/wis_issue_seq.sv
`timescale 1ns/1ps
module wis_issue_seq
  import wis_pkg::*;
#(
  parameter int NumWarps    = WARP_COUNT,
  parameter int LaneCount   = LANE_COUNT,
  parameter int WarpThreads = WARP_THREADS,
  localparam int SubCycles  = WarpThreads / LaneCount,
  localparam int IdW        = $clog2(NumWarps),
  localparam int SubW       = $clog2(SubCycles),
  localparam int ThreadW    = $clog2(WarpThreads)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NumWarps-1:0]          warpReady,
  input  logic [NumWarps-1:0]          warpAck,
  output logic                         issueValid,
  output logic [IdW-1:0]               warpId,
  output logic [SubW-1:0]              subCycle,
  output logic [LaneCount*ThreadW-1:0] laneThread
);
  seqStrobes_t    strobes;
  logic [IdW-1:0] selWarp;
  logic           atBoundary;

  wis_ctrl #(.NumWarps(NumWarps), .IdW(IdW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .warpReady (warpReady),
    .warpAck   (warpAck),
    .atBoundary(atBoundary),
    .strobes   (strobes),
    .selWarp   (selWarp)
  );

  wis_lanes #(
    .LaneCount(LaneCount), .IdW(IdW), .SubW(SubW),
    .SubCycles(SubCycles), .ThreadW(ThreadW)
  ) u_lanes (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .selWarp   (selWarp),
    .atBoundary(atBoundary),
    .issueValid(issueValid),
    .warpId    (warpId),
    .subCycle  (subCycle),
    .laneThread(laneThread)
  );
endmodule

// File: rtl/wis_issue_seq_chk.sv
`timescale 1ns/1ps
module wis_issue_seq_chk #(
  parameter int NumWarps  = 24,
  parameter int LaneCount = 8,
  parameter int IdW       = 5,
  parameter int SubW      = 2,
  parameter int SubCycles = 4,
  parameter int ThreadW   = 5
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NumWarps-1:0]          warpReady,
  input logic                         issueValid,
  input logic [IdW-1:0]               warpId,
  input logic [SubW-1:0]              subCycle,
  input logic [LaneCount*ThreadW-1:0] laneThread
);
  localparam logic [SubW-1:0] LastSub = SubW'(SubCycles - 1);

  assert_beat_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && subCycle != LastSub) |=>
      (issueValid && subCycle == $past(subCycle) + SubW'(1) && warpId == $past(warpId)));

  assert_start_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issueValid) |-> (subCycle == '0));

  assert_lane_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && subCycle != LastSub) |=>
      (laneThread[ThreadW-1:0] == $past(laneThread[ThreadW-1:0]) + ThreadW'(LaneCount)));

  assert_pick_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && subCycle == '0) |-> (|($past(warpReady) & (NumWarps'(1) << warpId))));

  assert_idle_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> (subCycle == '0));
endmodule

bind wis_issue_seq wis_issue_seq_chk #(
  .NumWarps(NumWarps), .LaneCount(LaneCount), .IdW(IdW),
  .SubW(SubW), .SubCycles(SubCycles), .ThreadW(ThreadW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .warpReady (warpReady),
  .issueValid(issueValid),
  .warpId    (warpId),
  .subCycle  (subCycle),
  .laneThread(laneThread)
);

// File: tb/sim_wis_issue_seq.sv
`timescale 1ns/1ps
module sim_wis_issue_seq;
  localparam int NW = 24;
  localparam int NL = 8;
  localparam int TW = 5;

  typedef struct {
    int    stamp;
    bit    valid;
    int    warp;
    int    sub;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NW-1:0]     warpReady = '0;
  logic [NW-1:0]     warpAck = '0;
  logic              issueValid;
  logic [4:0]        warpId;
  logic [1:0]        subCycle;
  logic [NL*TW-1:0]  laneThread;

  int   cyc = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;
  exp_t q[$];

  wis_issue_seq u0 (
    .clk(clk), .rstN(rstN), .warpReady(warpReady), .warpAck(warpAck),
    .issueValid(issueValid), .warpId(warpId), .subCycle(subCycle),
    .laneThread(laneThread)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pushIssue(int c, int w, string tag);
    for (int k = 0; k < 4; k++) q.push_back('{c + k, 1'b1, w, k, tag});
  endtask

  task automatic pushIdle(int c, string tag);
    q.push_back('{c, 1'b0, 0, 0, tag});
  endtask

  task automatic cleanup();
    warpReady = '0;
    warpAck   = '1;
    step(6);
    warpAck   = '0;
    step(1);
  endtask

  // Monitor: compare outputs against expected items in the middle of the cycle
  always @(negedge clk) begin
    exp_t e;
    bit   bad;
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      e = q.pop_front();
      nChecks++;
      bad = 1'b0;
      if (e.stamp < cyc) begin
        bad = 1'b1;
        $display("FAIL %s: item for cycle %0d missed (actual cycle %0d, expected %0d)",
                 e.tag, e.stamp, cyc, e.stamp);
      end else if (issueValid !== e.valid) begin
        bad = 1'b1;
        $display("FAIL %s: cycle %0d issueValid actual %0b expected %0b",
                 e.tag, cyc, issueValid, e.valid);
      end else if (!e.valid && subCycle !== 2'd0) begin
        bad = 1'b1;
        $display("FAIL %s: cycle %0d idle subCycle actual %0d expected 0", e.tag, cyc, subCycle);
      end else if (e.valid) begin
        if (warpId !== 5'(e.warp) || subCycle !== 2'(e.sub)) begin
          bad = 1'b1;
          $display("FAIL %s: cycle %0d warp/sub actual %0d/%0d expected %0d/%0d",
                   e.tag, cyc, warpId, subCycle, e.warp, e.sub);
        end
        for (int j = 0; j < NL; j++) begin
          if (!bad && laneThread[j*TW +: TW] !== 5'(8 * e.sub + j)) begin
            bad = 1'b1;
            $display("FAIL R3: cycle %0d lane %0d thread actual %0d expected %0d",
                     cyc, j, laneThread[j*TW +: TW], 8 * e.sub + j);
          end
        end
      end
      if (bad) nFails++;
    end
  end

  task automatic directCheck(bit ok, string msg, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", msg, act, expv);
    end
  endtask

  initial begin
    int c;
    step(3);
    // R1: in reset
    directCheck(issueValid === 1'b0, "R1 issueValid in reset", issueValid, 0);
    directCheck(subCycle === 2'd0, "R1 subCycle in reset", subCycle, 0);
    rstN = 1'b1;
    step(2);
    directCheck(issueValid === 1'b0, "R1 issueValid after reset", issueValid, 0);
    directCheck(subCycle === 2'd0, "R1 subCycle after reset", subCycle, 0);

    // S1: single warp, ready changes mid-warp (R2, R4, R7)
    c = cyc;
    warpReady = NW'(1) << 5;
    pushIssue(c + 1, 5, "R2");
    pushIssue(c + 5, 2, "R4");
    pushIdle(c + 9, "R7");
    step(1);
    warpReady = (NW'(1) << 5) | (NW'(1) << 2);
    step(10);
    cleanup();

    // S2: round robin with wrap, last pick was 2 (R5)
    c = cyc;
    warpReady = (NW'(1) << 0) | (NW'(1) << 3) | (NW'(1) << 23);
    pushIssue(c + 1, 3, "R5");
    pushIssue(c + 5, 23, "R5");
    pushIssue(c + 9, 0, "R5");
    pushIdle(c + 13, "R6");
    step(15);
    cleanup();

    // S3: ack held, warp reissues back to back, then drops ready (R7, R6)
    c = cyc;
    warpReady = NW'(1) << 7;
    warpAck   = NW'(1) << 7;
    pushIssue(c + 1, 7, "R7");
    pushIssue(c + 5, 7, "R7");
    pushIdle(c + 9, "R6");
    step(6);
    warpReady = '0;
    step(5);
    cleanup();

    // S4: ack only on the pick edge is lost (R7)
    c = cyc;
    warpReady = NW'(1) << 7;
    warpAck   = NW'(1) << 7;
    pushIssue(c + 1, 7, "R7");
    pushIdle(c + 5, "R7");
    pushIdle(c + 6, "R7");
    step(1);
    warpAck = '0;
    step(7);
    cleanup();

    // S5: two warps alternate under held ack, last pick was 7 (R5)
    c = cyc;
    warpReady = (NW'(1) << 4) | (NW'(1) << 9);
    warpAck   = '1;
    pushIssue(c + 1, 9, "R5");
    pushIssue(c + 5, 4, "R5");
    pushIssue(c + 9, 9, "R5");
    pushIdle(c + 13, "R6");
    step(10);
    warpReady = '0;
    step(5);
    cleanup();

    if (q.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL R2: %0d expected items left unchecked (expected 0)", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end (actual cycle %0d, expected end before)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule